// File: doc/BRIEF.md
# Microcode Branch Condition Evaluator

This block sits beside the microcode sequencer of a small processor and decides whether a conditional branch goes ahead. Two control bits from the current microinstruction select its behaviour. One enables the evaluation and the other inverts the result. Three opcode bits (instruction register bits 1 to 3) select one of eight condition functions of the zero, sign, overflow and carry flags. The carry flag follows the borrow-clear convention: carry is 0 after a subtraction that borrowed.

When evaluation is enabled, a true result sends the sequencer to the microinstruction's next-address field. A false result sends it back to microaddress 0, which is the instruction fetch step. When evaluation is disabled, the next field is always taken and the taken output stays low. The chosen address and the taken indication are both registered on the rising clock edge.

Top module: `ubr_eval_top`

## Requirements
- R1: After a synchronous reset, `next_uaddr` is 0 and `taken` is 0.
- R2: With `br_en`=0, one clock later `next_uaddr` equals `next_field` and `taken` is 0, whatever the flags, `ir_sel` and `br_neg` are.
- R3: With `br_en`=1, the raw condition is selected by `ir_sel` (instruction bits 1 to 3, bit 0 of `ir_sel` = instruction bit 1). The values are: 0, 1 and 6 give Z. 2 gives S^V. 3 gives (S^V)|Z. 4 gives !C. 5 gives !C|Z. 7 gives !Z.
- R4: With `br_en`=1, the decision is the raw condition XOR `br_neg`. Negation turns the eight rows into ne, ne, ge, gt, geu, gtu, ne and eq.
- R5: With `br_en`=1 and a true decision, one clock later `taken`=1 and `next_uaddr`=`next_field`.
- R6: With `br_en`=1 and a false decision, one clock later `taken`=0 and `next_uaddr`=0 (fetch).
- R7: The flag vector `flags` is packed as bit 3 = Z, bit 2 = S, bit 1 = V, bit 0 = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| br_en | input | 1 | Microcode bit that enables branch evaluation |
| br_neg | input | 1 | Microcode bit that inverts the condition |
| ir_sel | input | 3 | Instruction register bits 1 to 3 |
| flags | input | 4 | {Z, S, V, C} |
| next_field | input | UA_W | Next-address field of the microinstruction |
| taken | output | 1 | Registered branch-taken indication |
| next_uaddr | output | UA_W | Registered next microaddress |

## Verification
The hard cases are the rows where the sign and overflow flags cancel, and the less-or-equal rows where a single zero flag flips the result. Uniform random flags reach these cases only now and then. Directed sweeps therefore drive all 16 flag combinations through every one of the eight selector values, with both negate settings. A non-zero next field that is dropped to 0 on a false decision counts as a real observation only when the next field is non-zero. For that reason, the random stimulus never uses a zero next field in the evaluated cases.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
   localparam int FLAG_W = 4;
   localparam int SEL_W  = 3;
   localparam int FZ = 3;
   localparam int FS = 2;
   localparam int FV = 1;
   localparam int FC = 0;

   typedef enum logic [SEL_W-1:0] {
      SEL_EQ0 = 3'd0,
      SEL_EQ1 = 3'd1,
      SEL_LT  = 3'd2,
      SEL_LE  = 3'd3,
      SEL_LTU = 3'd4,
      SEL_LEU = 3'd5,
      SEL_EQ6 = 3'd6,
      SEL_NE  = 3'd7
   } cond_sel_e;
endpackage

// File: rtl/ubr_cond_lut.sv
module ubr_cond_lut
   import ubr_pkg::*;
(
   input  logic [SEL_W-1:0]  sel,
   input  logic [FLAG_W-1:0] flg,
   output logic              raw
);
   logic z, s, v, c, lt_s;
   always_comb begin
      z = flg[FZ];
      s = flg[FS];
      v = flg[FV];
      c = flg[FC];
      lt_s = s ^ v;
      unique case (cond_sel_e'(sel))
         SEL_EQ0, SEL_EQ1, SEL_EQ6: raw = z;
         SEL_LT:  raw = lt_s;
         SEL_LE:  raw = lt_s | z;
         SEL_LTU: raw = ~c;
         SEL_LEU: raw = ~c | z;
         SEL_NE:  raw = ~z;
         default: raw = 1'b0;
      endcase
   end
endmodule

// File: rtl/ubr_next_mux.sv
module ubr_next_mux #(
   parameter int UA_W = 8,
   parameter int FETCH_ADDR = 0
) (
   input  logic            en,
   input  logic            decide,
   input  logic [UA_W-1:0] nxt,
   output logic [UA_W-1:0] addr,
   output logic            tk
);
   localparam logic [UA_W-1:0] FETCH = UA_W'(FETCH_ADDR);
   always_comb begin
      tk   = en & decide;
      addr = (en && !decide) ? FETCH : nxt;
   end
endmodule

// File: rtl/ubr_eval_top.sv
module ubr_eval_top
   import ubr_pkg::*;
#(
   parameter int UA_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            br_en,
   input  logic            br_neg,
   input  logic [2:0]      ir_sel,
   input  logic [3:0]      flags,
   input  logic [UA_W-1:0] next_field,
   output logic            taken,
   output logic [UA_W-1:0] next_uaddr
);
   initial begin
      if (UA_W < 1 || UA_W > 32) $error("UA_W out of range");
   end

   logic raw_c, decide_c, tk_c;
   logic [UA_W-1:0] addr_c;

   ubr_cond_lut u_lut (.sel(ir_sel), .flg(flags), .raw(raw_c));

   assign decide_c = raw_c ^ br_neg;

   ubr_next_mux #(.UA_W(UA_W), .FETCH_ADDR(0)) u_mux (
      .en(br_en), .decide(decide_c), .nxt(next_field),
      .addr(addr_c), .tk(tk_c));

   always_ff @(posedge clk) begin
      if (rst) begin
         taken      <= 1'b0;
         next_uaddr <= '0;
      end else begin
         taken      <= tk_c;
         next_uaddr <= addr_c;
      end
   end
endmodule

// File: rtl/ubr_eval_chk.sv
module ubr_eval_chk #(
   parameter int UA_W = 8
) (
   input logic            clk,
   input logic            rst,
   input logic            br_en,
   input logic            br_neg,
   input logic [2:0]      ir_sel,
   input logic [3:0]      flags,
   input logic [UA_W-1:0] next_field,
   input logic            taken,
   input logic [UA_W-1:0] next_uaddr
);
   logic run;
   always_ff @(posedge clk) run <= !rst;

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (next_uaddr == '0 && !taken));
   assert_disabled_R2: assert property (@(posedge clk) disable iff (rst || !run)
      !br_en |=> (!taken && next_uaddr == $past(next_field)));
   assert_taken_R5: assert property (@(posedge clk) disable iff (rst || !run)
      taken |-> next_uaddr == $past(next_field));
   assert_fail_R6: assert property (@(posedge clk) disable iff (rst || !run)
      (br_en && next_field != '0) |=> (taken || next_uaddr == '0));
   assert_eq_row_R3: assert property (@(posedge clk) disable iff (rst || !run)
      (br_en && !br_neg && ir_sel == 3'd0) |=> (taken == $past(flags[3])));
   assert_neg_row_R4: assert property (@(posedge clk) disable iff (rst || !run)
      (br_en && br_neg && ir_sel == 3'd7) |=> (taken == $past(flags[3])));
endmodule

bind ubr_eval_top ubr_eval_chk #(.UA_W(UA_W)) u_chk (.*);

// File: tb/sim_ubr_eval_top.sv
`timescale 1ns/1ps
module sim_ubr_eval_top;
   localparam int UA_W = 8;
   logic clk = 0, rst = 1, br_en = 0, br_neg = 0;
   logic [2:0] ir_sel = 0;
   logic [3:0] flags = 0;
   logic [UA_W-1:0] next_field = 0;
   logic taken;
   logic [UA_W-1:0] next_uaddr;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ubr_eval_top #(.UA_W(UA_W)) u0 (.*);

   function automatic bit ref_raw(input logic [2:0] s, input logic [3:0] f);
      bit z, sg, v, c;
      z = f[3]; sg = f[2]; v = f[1]; c = f[0];
      case (s)
         3'd0, 3'd1, 3'd6: return z;
         3'd2: return sg ^ v;
         3'd3: return (sg ^ v) | z;
         3'd4: return !c;
         3'd5: return !c | z;
         default: return !z;
      endcase
   endfunction

   task automatic check(input string req, input logic [UA_W-1:0] ea, input logic et);
      n_chk++;
      if (next_uaddr !== ea || taken !== et) begin
         n_bad++;
         $display("FAIL %s: addr=%0d taken=%0b expected addr=%0d taken=%0b (sel=%0d f=%b en=%0b neg=%0b)",
                  req, next_uaddr, taken, ea, et, ir_sel, flags, br_en, br_neg);
      end
   endtask

   task automatic apply(input bit en, input bit ng, input logic [2:0] s,
                        input logic [3:0] f, input logic [UA_W-1:0] nf, input string req);
      bit d;
      br_en = en; br_neg = ng; ir_sel = s; flags = f; next_field = nf;
      @(posedge clk); #5;
      d = ref_raw(s, f) ^ ng;
      if (!en) check(req, nf, 1'b0);
      else if (d) check(req, nf, 1'b1);
      else check(req, '0, 1'b0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      next_field = 8'hA5;
      repeat (2) @(posedge clk);
      #5;
      check("R1 reset", '0, 1'b0);
      rst = 0;
      @(negedge clk);
      // R2: disabled passes next field regardless
      apply(0, 1, 3'd7, 4'b0000, 8'h3C, "R2");
      apply(0, 0, 3'd0, 4'b1000, 8'hC3, "R2");
      // R3/R4/R5/R6/R7 exhaustive sweep
      for (int s = 0; s < 8; s++)
         for (int f = 0; f < 16; f++)
            for (int ng = 0; ng < 2; ng++)
               apply(1, ng[0], s[2:0], f[3:0], 8'(1 + s*16 + f), "R3 R4 R5 R6 R7");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [UA_W-1:0] nf;
         nf = UA_W'($urandom_range(1, 255));
         apply($urandom_range(0, 3) != 0, $urandom_range(0, 1), 3'($urandom_range(0, 7)),
               4'($urandom_range(0, 15)), nf, "R2 R5 R6 random");
      end
      // reset mid-run
      apply(1, 0, 3'd7, 4'b0000, 8'h77, "R5");
      rst = 1; @(posedge clk); #5;
      check("R1 reset again", '0, 1'b0);
      rst = 0;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule